// File: doc/BRIEF.md
# Directory DMA-Read Hold Controller

This block is the home-node directory logic for one cache line. It accepts processor requests (shared read, exclusive read, owner writebacks) and coherent DMA reads and writes. It then decides where each one is served: memory, the owning cache, or a set of invalidations to sharers. It keeps the line's stable state (uncached, shared, owned, modified), the owner's identifier and a sharer bit vector.

When a DMA read hits a line that a cache owns, the directory forwards the read to that owner. The owner then supplies the DMA engine directly. The line is then frozen in a dedicated hold state until the owner confirms, through a DMA acknowledgement, that the engine has been served. A DMA write to an owned line also freezes the line, until the owner's data has come back. Any request that arrives while the line is frozen is parked in a one-entry retry slot. The slot replays the request as soon as the line is stable again, so requests are served in arrival order.

All outputs are single-cycle pulses, registered on the clock edge that accepts the request or response.

Top module: `dirdma_line_ctrl`

## Requirements
- R1: After reset, `dir_state` reads 0 (uncached) and `req_ready` is 1. `fwd_valid`, `inv_valid`, `mem_valid` and `ack_err` are all 0. State codes are 0 uncached, 1 shared, 2 owned, 3 modified, 4 owned-hold, 5 modified-hold and 6 write-wait. Request kind codes are 0 shared read, 1 exclusive read, 2 owned writeback, 3 modified writeback, 4 DMA read and 5 DMA write. Response kind codes are 1 DMA acknowledgement and 2 owner data.
- R2: In shared state, a DMA read raises `mem_valid` with `mem_requester` equal to the requester. No invalidation is sent and the state stays shared.
- R3: In owned state, a DMA read is forwarded to the owner with the following fields:
  - `fwd_valid` = 1, `fwd_target` = owner, `fwd_kind` = 4
  - `fwd_agent_dma` = 1
  - `fwd_acks` = current number of sharers

  The state becomes 4.
- R4: In modified state, a DMA read is forwarded to the owner in the same way, and the state becomes 5.
- R5: A DMA acknowledgement returns state 4 to 2 and state 5 to 3, with no output pulse in that cycle.
- R6: A request accepted in states 4, 5 or 6 produces no output and is parked, and `req_ready` stays 0 while it is parked. The cycle after the line leaves the hold state, the parked request is served as if it had just arrived. `req_ready` then returns to 1.
- R7: In owned or modified state, a DMA write has the following effects:
  - It forwards to the owner with `fwd_dir_is_req` = 1 and `fwd_kind` = 5.
  - It invalidates all sharers.
  - It moves the state to 6.

  An owner-data response in state 6 moves the line to uncached.
- R8: An invalidation mask (`inv_mask`, bit n = agent n) never includes the requester. `inv_valid` is 1 only when the mask is non-zero.
- R9: A DMA acknowledgement in any state other than 4 or 5 pulses `ack_err` for exactly one cycle and leaves the state unchanged.
- R10: Processor reads are handled as follows:
  - A shared read in uncached or shared state is served from memory and adds the requester as a sharer, leaving the line shared.
  - An exclusive read in shared state is served from memory, invalidates the other sharers and makes the requester the owner, leaving the line modified.
  - A shared read in modified state is forwarded to the owner and makes the line owned.
  - A forward's `fwd_acks` equals the sharer count before the request.
- R11: A writeback from an agent that is not the owner changes nothing. A writeback from the owner of an owned line with sharers leaves the line shared, with the sharers kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (retry slot empty) |
| req_kind | input | 3 | Request kind code |
| req_src | input | NODE_W | Requesting agent identifier |
| rsp_valid | input | 1 | Response present |
| rsp_kind | input | 2 | Response kind code |
| fwd_valid | output | 1 | Forward-to-owner pulse |
| fwd_kind | output | 3 | Kind of the forwarded request |
| fwd_requester | output | NODE_W | Original requester |
| fwd_dir_is_req | output | 1 | Directory stands as requester (DMA write) |
| fwd_agent_dma | output | 1 | Original requester is a DMA engine |
| fwd_target | output | NODE_W | Owner receiving the forward |
| fwd_acks | output | CNT_W | Sharer count carried as ack count |
| inv_valid | output | 1 | Invalidation pulse |
| inv_mask | output | NODES | Agents to invalidate |
| inv_requester | output | NODE_W | Requester named in the invalidation |
| mem_valid | output | 1 | Memory fetch pulse |
| mem_requester | output | NODE_W | Agent that receives the memory data |
| ack_err | output | 1 | Unexpected DMA acknowledgement pulse |
| dir_state | output | 3 | Current line state code |

## Verification
The assertions assume that `req_valid` is only raised when `req_ready` is high. They also assume that responses arrive only for a transaction the directory actually started, except where an unexpected acknowledgement is deliberately injected to exercise the error pulse. The directed tasks drive every input on the falling edge and present one request or one response per cycle. They send a hold-state request only while the retry slot is empty. They use request and response codes inside the defined ranges, so the parked-request and arrival-order properties stay meaningful.

// File: rtl/dirdma_pkg.sv
package dirdma_pkg;

   typedef enum logic [2:0] {
      LS_I     = 3'd0,
      LS_S     = 3'd1,
      LS_O     = 3'd2,
      LS_M     = 3'd3,
      LS_OHOLD = 3'd4,
      LS_MHOLD = 3'd5,
      LS_WDATA = 3'd6
   } line_st_e;

   typedef enum logic [2:0] {
      RQ_GETS  = 3'd0,
      RQ_GETX  = 3'd1,
      RQ_PUTO  = 3'd2,
      RQ_PUTX  = 3'd3,
      RQ_DMARD = 3'd4,
      RQ_DMAWR = 3'd5
   } rq_kind_e;

   localparam logic [1:0] RS_DMA_ACK  = 2'd1;
   localparam logic [1:0] RS_OWN_DATA = 2'd2;

   function automatic logic st_frozen(line_st_e s);
      return (s == LS_OHOLD) || (s == LS_MHOLD) || (s == LS_WDATA);
   endfunction

   function automatic logic kind_is_dma(rq_kind_e k);
      return (k == RQ_DMARD) || (k == RQ_DMAWR);
   endfunction

endpackage

// File: rtl/dirdma_retry_slot.sv
module dirdma_retry_slot
   import dirdma_pkg::*;
#(
   parameter int NODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  rq_kind_e          load_kind,
   input  logic [NODE_W-1:0] load_src,
   input  logic              drain,
   output logic              held,
   output rq_kind_e          held_kind,
   output logic [NODE_W-1:0] held_src
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_kind <= RQ_GETS;
         held_src  <= '0;
      end else if (load) begin
         held      <= 1'b1;
         held_kind <= load_kind;
         held_src  <= load_src;
      end else if (drain) begin
         held      <= 1'b0;
      end
   end

   // R6: one parked request at a time; a second park would lose ordering
   assert_no_double_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !held);

   // R6: a drain always follows an occupied slot
   assert_drain_only_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drain |-> held);

endmodule

// File: rtl/dirdma_decide.sv
module dirdma_decide
   import dirdma_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int NODE_W = 2,
   parameter int CNT_W  = 3
) (
   input  line_st_e          cur_st,
   input  logic [NODE_W-1:0] cur_owner,
   input  logic [NODES-1:0]  cur_shr,
   input  logic              act_vld,
   input  rq_kind_e          act_kind,
   input  logic [NODE_W-1:0] act_src,
   input  logic              rsp_vld,
   input  logic [1:0]        rsp_kind,
   output line_st_e          nx_st,
   output logic [NODE_W-1:0] nx_owner,
   output logic [NODES-1:0]  nx_shr,
   output logic              park,
   output logic              fwd_go,
   output logic              fwd_dir,
   output logic [CNT_W-1:0]  fwd_cnt,
   output logic              inv_go,
   output logic [NODES-1:0]  inv_bits,
   output logic              mem_go,
   output logic              err_go
);

   logic [NODES-1:0] src_bit;
   logic [NODES-1:0] others;
   logic             dma_ack;
   logic             own_data;
   logic             from_owner;

   for (genvar g = 0; g < NODES; g++) begin : g_srcsel
      assign src_bit[g] = (act_src == NODE_W'(g));
   end

   assign others     = cur_shr & ~src_bit;
   assign fwd_cnt    = CNT_W'($countones(cur_shr));
   assign dma_ack    = rsp_vld && (rsp_kind == RS_DMA_ACK);
   assign own_data   = rsp_vld && (rsp_kind == RS_OWN_DATA);
   assign from_owner = (act_src == cur_owner);
   assign inv_go     = |inv_bits;

   always_comb begin
      nx_st    = cur_st;
      nx_owner = cur_owner;
      nx_shr   = cur_shr;
      park     = 1'b0;
      fwd_go   = 1'b0;
      fwd_dir  = 1'b0;
      inv_bits = '0;
      mem_go   = 1'b0;
      err_go   = 1'b0;

      if (dma_ack) begin
         case (cur_st)
            LS_OHOLD: nx_st = LS_O;
            LS_MHOLD: nx_st = LS_M;
            default:  err_go = 1'b1;
         endcase
      end
      if (own_data && (cur_st == LS_WDATA)) begin
         nx_st  = LS_I;
         nx_shr = '0;
      end

      if (act_vld) begin
         if (st_frozen(cur_st)) begin
            park = 1'b1;
         end else begin
            case (cur_st)
               LS_I: begin
                  case (act_kind)
                     RQ_GETS:  begin mem_go = 1'b1; nx_st = LS_S; nx_shr = src_bit; end
                     RQ_GETX:  begin mem_go = 1'b1; nx_st = LS_M; nx_owner = act_src; nx_shr = '0; end
                     RQ_DMARD: mem_go = 1'b1;
                     default:  ;
                  endcase
               end
               LS_S: begin
                  case (act_kind)
                     RQ_GETS:  begin mem_go = 1'b1; nx_shr = cur_shr | src_bit; end
                     RQ_GETX:  begin
                        mem_go = 1'b1; inv_bits = others;
                        nx_st = LS_M; nx_owner = act_src; nx_shr = '0;
                     end
                     RQ_DMARD: mem_go = 1'b1;
                     RQ_DMAWR: begin inv_bits = others; nx_st = LS_I; nx_shr = '0; end
                     default:  ;
                  endcase
               end
               LS_O: begin
                  case (act_kind)
                     RQ_GETS:  begin fwd_go = 1'b1; nx_shr = cur_shr | src_bit; end
                     RQ_GETX:  begin
                        fwd_go = 1'b1; inv_bits = others;
                        nx_st = LS_M; nx_owner = act_src; nx_shr = '0;
                     end
                     RQ_DMARD: begin fwd_go = 1'b1; nx_st = LS_OHOLD; end
                     RQ_DMAWR: begin
                        fwd_go = 1'b1; fwd_dir = 1'b1; inv_bits = others; nx_st = LS_WDATA;
                     end
                     RQ_PUTO, RQ_PUTX: begin
                        if (from_owner) nx_st = (|cur_shr) ? LS_S : LS_I;
                     end
                     default:  ;
                  endcase
               end
               LS_M: begin
                  case (act_kind)
                     RQ_GETS:  begin fwd_go = 1'b1; nx_st = LS_O; nx_shr = src_bit; end
                     RQ_GETX:  begin fwd_go = 1'b1; nx_owner = act_src; end
                     RQ_DMARD: begin fwd_go = 1'b1; nx_st = LS_MHOLD; end
                     RQ_DMAWR: begin
                        fwd_go = 1'b1; fwd_dir = 1'b1; inv_bits = others; nx_st = LS_WDATA;
                     end
                     RQ_PUTO, RQ_PUTX: begin
                        if (from_owner) begin nx_st = LS_I; nx_shr = '0; end
                     end
                     default:  ;
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dirdma_line_ctrl.sv
module dirdma_line_ctrl
   import dirdma_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
   parameter int CNT_W  = $clog2(NODES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_kind,
   input  logic [NODE_W-1:0] req_src,
   input  logic              rsp_valid,
   input  logic [1:0]        rsp_kind,
   output logic              fwd_valid,
   output logic [2:0]        fwd_kind,
   output logic [NODE_W-1:0] fwd_requester,
   output logic              fwd_dir_is_req,
   output logic              fwd_agent_dma,
   output logic [NODE_W-1:0] fwd_target,
   output logic [CNT_W-1:0]  fwd_acks,
   output logic              inv_valid,
   output logic [NODES-1:0]  inv_mask,
   output logic [NODE_W-1:0] inv_requester,
   output logic              mem_valid,
   output logic [NODE_W-1:0] mem_requester,
   output logic              ack_err,
   output logic [2:0]        dir_state
);

   if (NODES < 2 || NODES > 64) begin : g_bad_nodes
      $error("dirdma_line_ctrl: NODES must lie in 2..64");
   end
   if (NODE_W < $clog2(NODES)) begin : g_bad_nodew
      $error("dirdma_line_ctrl: NODE_W too narrow for NODES");
   end
   if (CNT_W < $clog2(NODES + 1)) begin : g_bad_cntw
      $error("dirdma_line_ctrl: CNT_W too narrow for sharer count");
   end

   line_st_e          st_q, st_d;
   logic [NODE_W-1:0] owner_q, owner_d;
   logic [NODES-1:0]  shr_q, shr_d;

   logic              held;
   rq_kind_e          held_kind;
   logic [NODE_W-1:0] held_src;

   logic              retry_go, take_in, act_vld;
   rq_kind_e          act_kind;
   logic [NODE_W-1:0] act_src;

   logic              park, fwd_go, fwd_dir, inv_go, mem_go, err_go;
   logic [CNT_W-1:0]  fwd_cnt;
   logic [NODES-1:0]  inv_bits;

   assign retry_go  = held && !st_frozen(st_q);
   assign req_ready = !held;
   assign take_in   = req_valid && !held;
   assign act_vld   = retry_go || take_in;
   assign act_kind  = retry_go ? held_kind : rq_kind_e'(req_kind);
   assign act_src   = retry_go ? held_src : req_src;
   assign dir_state = st_q;

   dirdma_retry_slot #(.NODE_W(NODE_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (park),
      .load_kind (act_kind),
      .load_src  (act_src),
      .drain     (retry_go),
      .held      (held),
      .held_kind (held_kind),
      .held_src  (held_src)
   );

   dirdma_decide #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_decide (
      .cur_st    (st_q),
      .cur_owner (owner_q),
      .cur_shr   (shr_q),
      .act_vld   (act_vld),
      .act_kind  (act_kind),
      .act_src   (act_src),
      .rsp_vld   (rsp_valid),
      .rsp_kind  (rsp_kind),
      .nx_st     (st_d),
      .nx_owner  (owner_d),
      .nx_shr    (shr_d),
      .park      (park),
      .fwd_go    (fwd_go),
      .fwd_dir   (fwd_dir),
      .fwd_cnt   (fwd_cnt),
      .inv_go    (inv_go),
      .inv_bits  (inv_bits),
      .mem_go    (mem_go),
      .err_go    (err_go)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q           <= LS_I;
         owner_q        <= '0;
         shr_q          <= '0;
         fwd_valid      <= 1'b0;
         fwd_kind       <= '0;
         fwd_requester  <= '0;
         fwd_dir_is_req <= 1'b0;
         fwd_agent_dma  <= 1'b0;
         fwd_target     <= '0;
         fwd_acks       <= '0;
         inv_valid      <= 1'b0;
         inv_mask       <= '0;
         inv_requester  <= '0;
         mem_valid      <= 1'b0;
         mem_requester  <= '0;
         ack_err        <= 1'b0;
      end else begin
         st_q           <= st_d;
         owner_q        <= owner_d;
         shr_q          <= shr_d;
         fwd_valid      <= fwd_go;
         fwd_kind       <= act_kind;
         fwd_requester  <= act_src;
         fwd_dir_is_req <= fwd_go && fwd_dir;
         fwd_agent_dma  <= fwd_go && kind_is_dma(act_kind);
         fwd_target     <= owner_q;
         fwd_acks       <= fwd_cnt;
         inv_valid      <= inv_go;
         inv_mask       <= inv_bits;
         inv_requester  <= act_src;
         mem_valid      <= mem_go;
         mem_requester  <= act_src;
         ack_err        <= err_go;
      end
   end

   // R6: a frozen line emits nothing in the following cycle
   assert_frozen_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_frozen(st_q) |=> (!fwd_valid && !inv_valid && !mem_valid));

   // R5: DMA acknowledgement releases each hold state to its stable state
   assert_ohold_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_OHOLD && rsp_valid && rsp_kind == RS_DMA_ACK) |=> (st_q == LS_O));
   assert_mhold_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_MHOLD && rsp_valid && rsp_kind == RS_DMA_ACK) |=> (st_q == LS_M));

   // R9: error pulse only after a stray DMA acknowledgement, state kept
   assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RS_DMA_ACK && !st_frozen(st_q) && !act_vld)
      |=> (ack_err && st_q == $past(st_q)));

   // R3 / R4: forwards only come out of owned or modified lines
   assert_fwd_from_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> ($past(st_q) == LS_O || $past(st_q) == LS_M));

   // R2: memory fetches only come out of uncached or shared lines
   assert_mem_from_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> ($past(st_q) == LS_I || $past(st_q) == LS_S));

   // R4: a DMA read leaving a modified line enters its hold state
   assert_dmard_m_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vld && act_kind == RQ_DMARD && st_q == LS_M) |=> (st_q == LS_MHOLD && fwd_agent_dma));

   // R8: invalidation never targets its own requester
   assert_inv_not_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !inv_mask[inv_requester]);

endmodule

// File: tb/tb_dirdma_line_ctrl.sv
`timescale 1ns/1ps
module tb_dirdma_line_ctrl;

   localparam int NODES  = 4;
   localparam int NODE_W = 2;
   localparam int CNT_W  = 3;
   localparam int WATCHDOG = 5000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [2:0]        req_kind = '0;
   logic [NODE_W-1:0] req_src = '0;
   logic              rsp_valid = 1'b0;
   logic [1:0]        rsp_kind = '0;
   logic              fwd_valid;
   logic [2:0]        fwd_kind;
   logic [NODE_W-1:0] fwd_requester;
   logic              fwd_dir_is_req;
   logic              fwd_agent_dma;
   logic [NODE_W-1:0] fwd_target;
   logic [CNT_W-1:0]  fwd_acks;
   logic              inv_valid;
   logic [NODES-1:0]  inv_mask;
   logic [NODE_W-1:0] inv_requester;
   logic              mem_valid;
   logic [NODE_W-1:0] mem_requester;
   logic              ack_err;
   logic [2:0]        dir_state;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;

   always #2 clk = ~clk;

   dirdma_line_ctrl #(.NODES(NODES)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_src(req_src),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_requester(fwd_requester),
      .fwd_dir_is_req(fwd_dir_is_req), .fwd_agent_dma(fwd_agent_dma),
      .fwd_target(fwd_target), .fwd_acks(fwd_acks),
      .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_requester(inv_requester),
      .mem_valid(mem_valid), .mem_requester(mem_requester),
      .ack_err(ack_err), .dir_state(dir_state)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic req(input int kind, input int src);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(kind); req_src = NODE_W'(src);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rsp(input int kind);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_kind = 2'(kind);
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 state", dir_state, 0);
      check("R1 ready", req_ready, 1);
      check("R1 outputs", {fwd_valid, inv_valid, mem_valid, ack_err}, 0);
   endtask

   task automatic t_shared_dma_read;
      req(0, 0); check("R10 gets mem", mem_valid, 1); check("R10 state S", dir_state, 1);
      req(0, 1); check("R10 gets2 state", dir_state, 1);
      req(4, 3);
      check("R2 mem", mem_valid, 1); check("R2 mem req", mem_requester, 3);
      check("R2 no inv", inv_valid, 0); check("R2 stays S", dir_state, 1);
   endtask

   task automatic t_getx_from_shared;
      req(1, 2);
      check("R10 getx inv mask", inv_mask, 4'b0011); check("R10 getx mem", mem_valid, 1);
      check("R10 getx state M", dir_state, 3);
   endtask

   task automatic t_m_dma_read_and_park;
      req(4, 3);
      check("R4 fwd", fwd_valid, 1); check("R4 target", fwd_target, 2);
      check("R4 kind", fwd_kind, 4); check("R4 dma agent", fwd_agent_dma, 1);
      check("R4 state MD", dir_state, 5);
      req(0, 0);
      check("R6 parked silent", {fwd_valid, inv_valid, mem_valid}, 0);
      check("R6 ready low", req_ready, 0); check("R6 still MD", dir_state, 5);
      rsp(1);
      check("R5 MD to M", dir_state, 3); check("R5 no pulse", fwd_valid, 0);
      @(negedge clk);
      check("R6 replay fwd", fwd_valid, 1); check("R6 replay req", fwd_requester, 0);
      check("R6 replay kind", fwd_kind, 0); check("R6 replay state O", dir_state, 2);
      check("R6 ready back", req_ready, 1);
   endtask

   task automatic t_o_dma_read;
      req(0, 1);
      check("R10 fwd acks", fwd_acks, 1); check("R10 fwd target", fwd_target, 2);
      req(4, 3);
      check("R3 fwd", fwd_valid, 1); check("R3 acks", fwd_acks, 2);
      check("R3 dma agent", fwd_agent_dma, 1); check("R3 dir flag", fwd_dir_is_req, 0);
      check("R3 state OD", dir_state, 4);
      rsp(1); check("R5 OD to O", dir_state, 2);
   endtask

   task automatic t_stray_ack;
      rsp(1);
      check("R9 err pulse", ack_err, 1); check("R9 state kept", dir_state, 2);
      @(negedge clk); check("R9 one cycle", ack_err, 0);
   endtask

   task automatic t_o_dma_write;
      req(5, 3);
      check("R7 fwd dir", fwd_dir_is_req, 1); check("R7 kind", fwd_kind, 5);
      check("R7 inv mask", inv_mask, 4'b0011); check("R7 state", dir_state, 6);
      rsp(2); check("R7 data to I", dir_state, 0);
   endtask

   task automatic t_inv_excludes_self;
      req(0, 0); req(0, 1);
      req(1, 0);
      check("R8 mask", inv_mask, 4'b0010); check("R8 inv req", inv_requester, 0);
      check("R8 state M", dir_state, 3);
   endtask

   task automatic t_puts;
      req(3, 1);
      check("R11 nonowner silent", {fwd_valid, inv_valid, mem_valid}, 0);
      check("R11 nonowner state", dir_state, 3);
      req(0, 1);
      check("R11 owner kept", fwd_target, 0); check("R10 M gets to O", dir_state, 2);
      req(2, 0); check("R11 owner put to S", dir_state, 1);
      req(1, 2); check("R11 sharer kept", inv_mask, 4'b0010); check("R11 state M", dir_state, 3);
   endtask

   task automatic t_m_dma_write;
      req(5, 3);
      check("R7 M fwd dir", fwd_dir_is_req, 1); check("R7 M target", fwd_target, 2);
      check("R7 M no inv", inv_valid, 0); check("R7 M state", dir_state, 6);
      rsp(2); check("R7 M data to I", dir_state, 0);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= WATCHDOG) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=%0d expected=<%0d", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_shared_dma_read;
      t_getx_from_shared;
      t_m_dma_read_and_park;
      t_o_dma_read;
      t_stray_ack;
      t_o_dma_write;
      t_inv_excludes_self;
      t_puts;
      t_m_dma_write;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule